// File: doc/BRIEF.md
# Jacobi Relaxation Stencil Array

This block is a two-dimensional array of identical unsigned integer cells that relaxes a discretized boundary-value problem with the Jacobi method. Each cell holds one grid value. On every relaxation step, all cells at once take the truncated mean of their four nearest neighbours. A ring of fixed edge values surrounds the array and feeds the cells on its border.

Initial cell values and edge values are loaded through a serial shift chain. Results leave through the same chain, one value per clock. After the chain is loaded, a single start pulse runs a preset number of relaxation steps and then raises a done flag. The host then shifts the results out, and it may shift the next problem in at the same time.

Top module: `jacobiGrid`

## Requirements
- R1: After reset, every cell and edge value is zero, `done` is low and `scanOut` is zero.
- R2: The chain has ROWS*COLS + 2*COLS + 2*ROWS positions. Interior cell (r,c) sits at position r*COLS+c. After the cells come the north edge values by column, then the south edge values by column, then the west edge values by row, then the east edge values by row. `scanOut` shows position 0. On each clock with `scanEn` high, every position takes the value of the next one, and the last position takes `scanIn`.
- R3: With `scanEn` low and no run in progress, all stored values hold.
- R4: A relaxation step sets each cell to (north+south+east+west) >> 2. The sum is formed in WIDTH+2 bits, so the result truncates and never overflows.
- R5: All cells update on the same edge from the values held before that edge.
- R6: Border cells use the edge value on the missing side. Edge values never change except by shifting.
- R7: A start pulse clears the step counter. Exactly MAX_ITER steps follow, one per clock. `done` rises on the edge of the last step and then holds.
- R8: `done` falls on the edge after a start pulse or a shift clock.
- R9: Raising `scanEn` during a run stops it. No further steps are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| scanEn | input | 1 | Shifts the chain by one position per clock |
| scanIn | input | WIDTH | Value entering the last chain position |
| scanOut | output | WIDTH | Value at chain position 0 |
| done | output | 1 | Run finished; holds until start or shift |

## Verification
The bench checks the shifted-out grid against a software model that runs the same truncating four-neighbour mean. A design that let cells read values already updated on the same edge would converge faster and drift away from the model. A design that swapped or mis-indexed edge segments would corrupt only the border rows or columns. A grid driven to the top value on every cell and edge must stay at the top value, so a sum held in WIDTH bits would visibly wrap. `done` is sampled one step before and one step after the expected count to catch off-by-one counters. A run is also aborted mid-way to confirm that stepping halts at the shift.

// File: rtl/jacobiPkg.sv
package jacobiPkg;
  typedef struct packed {
    logic shiftEn;
    logic iterEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/jacobiNode.sv
module jacobiNode #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] northV,
  input  logic [WIDTH-1:0] southV,
  input  logic [WIDTH-1:0] eastV,
  input  logic [WIDTH-1:0] westV,
  output logic [WIDTH-1:0] meanV
);
  localparam int SUM_W = WIDTH + 2;
  logic [SUM_W-1:0] sumV;

  always_comb begin
    sumV = SUM_W'(northV) + SUM_W'(southV) + SUM_W'(eastV) + SUM_W'(westV);
    meanV = sumV[SUM_W-1:2];
  end
endmodule

// File: rtl/jacobiDatapath.sv
module jacobiDatapath
  import jacobiPkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [WIDTH-1:0]   scanIn,
  output logic [WIDTH-1:0]   scanOut
);
  localparam int NODES     = ROWS * COLS;
  localparam int NORTH_B   = NODES;
  localparam int SOUTH_B   = NODES + COLS;
  localparam int WEST_B    = NODES + 2 * COLS;
  localparam int EAST_B    = NODES + 2 * COLS + ROWS;
  localparam int CHAIN_LEN = NODES + 2 * COLS + 2 * ROWS;

  logic [WIDTH-1:0] cellQ [CHAIN_LEN];
  logic [WIDTH-1:0] meanV [NODES];

  assign scanOut = cellQ[0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int NI = (r == 0)        ? NORTH_B + c : (r - 1) * COLS + c;
      localparam int SI = (r == ROWS - 1) ? SOUTH_B + c : (r + 1) * COLS + c;
      localparam int WI = (c == 0)        ? WEST_B + r  : r * COLS + c - 1;
      localparam int EI = (c == COLS - 1) ? EAST_B + r  : r * COLS + c + 1;
      jacobiNode #(.WIDTH(WIDTH)) u_node (
        .northV(cellQ[NI]),
        .southV(cellQ[SI]),
        .eastV (cellQ[EI]),
        .westV (cellQ[WI]),
        .meanV (meanV[r * COLS + c])
      );
    end
  end

  for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
    logic [WIDTH-1:0] shiftSrc;
    logic [WIDTH-1:0] iterSrc;
    logic             iterHit;
    if (k == CHAIN_LEN - 1) begin : g_tail
      assign shiftSrc = scanIn;
    end else begin : g_link
      assign shiftSrc = cellQ[k + 1];
    end
    if (k < NODES) begin : g_inner
      assign iterSrc = meanV[k];
      assign iterHit = strobes.iterEn;
    end else begin : g_edge
      assign iterSrc = cellQ[k];
      assign iterHit = 1'b0;
      // R6
      edge_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.shiftEn |=> $stable(cellQ[k]));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cellQ[k] <= '0;
      else if (strobes.shiftEn) cellQ[k] <= shiftSrc;
      else if (iterHit)         cellQ[k] <= iterSrc;
    end
  end
endmodule

// File: rtl/jacobiCtrl.sv
module jacobiCtrl
  import jacobiPkg::*;
#(
  parameter int MAX_ITER = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         scanEn,
  output ctrlStrobes_t strobes,
  output logic         done
);
  localparam int CNT_W = $clog2(MAX_ITER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_ITER - 1);

  logic [CNT_W-1:0] iterCnt;
  logic             running;

  assign strobes.shiftEn = scanEn;
  assign strobes.iterEn  = running && !scanEn && !start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iterCnt <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (scanEn) begin
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      iterCnt <= '0;
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running) begin
      iterCnt <= iterCnt + 1'b1;
      if (iterCnt == LAST) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt <= CNT_W'(MAX_ITER));
  // R7
  done_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strobes.iterEn));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start && !scanEn) |=> done);
  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);
  // R9
  scan_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> (!done && !running));
endmodule

// File: rtl/jacobiGrid.sv
module jacobiGrid
  import jacobiPkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int WIDTH    = 8,
  parameter int MAX_ITER = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             scanEn,
  input  logic [WIDTH-1:0] scanIn,
  output logic [WIDTH-1:0] scanOut,
  output logic             done
);
  ctrlStrobes_t strobes;

  jacobiCtrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .scanEn(scanEn),
    .strobes(strobes), .done(done)
  );

  jacobiDatapath #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .scanIn(scanIn), .scanOut(scanOut)
  );
endmodule

// File: tb/jacobiGrid_test.sv
`timescale 1ns/1ps
module jacobiGrid_test;
  localparam int ROWS = 4, COLS = 4, WIDTH = 8, MAX_ITER = 64;
  localparam int NODES = ROWS * COLS;
  localparam int CHAIN = NODES + 2 * COLS + 2 * ROWS;
  localparam int MAXV = (1 << WIDTH) - 1;

  logic clk = 0, rstN = 0, start = 0, scanEn = 0;
  logic [WIDTH-1:0] scanIn = '0;
  logic [WIDTH-1:0] scanOut;
  logic done;
  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int model [CHAIN];

  always #2.5 clk = ~clk;

  jacobiGrid #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .MAX_ITER(MAX_ITER)) uut (
    .clk(clk), .rstN(rstN), .start(start), .scanEn(scanEn),
    .scanIn(scanIn), .scanOut(scanOut), .done(done)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2 position map
  function automatic int nbr(int r, int c, int dr, int dc);
    if (r + dr < 0)     return NODES + c;
    if (r + dr >= ROWS) return NODES + COLS + c;
    if (c + dc < 0)     return NODES + 2 * COLS + r;
    if (c + dc >= COLS) return NODES + 2 * COLS + ROWS + r;
    return (r + dr) * COLS + c + dc;
  endfunction

  // R4 R5 R6: one synchronous truncating step
  task automatic modelStep();
    int nxt [NODES];
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        nxt[r * COLS + c] = (model[nbr(r, c, -1, 0)] + model[nbr(r, c, 1, 0)] +
                             model[nbr(r, c, 0, -1)] + model[nbr(r, c, 0, 1)]) >> 2;
    for (int k = 0; k < NODES; k++) model[k] = nxt[k];
  endtask

  task automatic loadChain();
    for (int k = 0; k < CHAIN; k++) begin
      @(negedge clk); scanEn = 1; scanIn = WIDTH'(model[k]);
    end
    @(negedge clk); scanEn = 0;
  endtask

  task automatic unloadChain(string req);
    for (int k = 0; k < CHAIN; k++) begin
      @(negedge clk);
      check(req, int'(scanOut), model[k]);
      scanEn = 1; scanIn = '0;
    end
    @(negedge clk); scanEn = 0;
    for (int k = 0; k < CHAIN; k++) model[k] = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic fullRun(string req);
    loadChain();
    pulseStart();
    for (int i = 1; i <= MAX_ITER; i++) begin
      @(negedge clk);
      if (i == MAX_ITER - 1) check("R7 done early", int'(done), 0);
      if (i == MAX_ITER)     check("R7 done at count", int'(done), 1);
    end
    repeat (5) @(negedge clk);
    check("R7 done holds", int'(done), 1);
    for (int i = 0; i < MAX_ITER; i++) modelStep();
    unloadChain(req);
  endtask

  task automatic randomFill();
    for (int k = 0; k < CHAIN; k++) model[k] = int'($urandom_range(MAXV, 0));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < CHAIN; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    check("R1 scanOut", int'(scanOut), 0);
    check("R1 done", int'(done), 0);
    rstN = 1;
    @(negedge clk);
    unloadChain("R1 reset contents");

    // R2 shift order round trip
    randomFill();
    loadChain();
    unloadChain("R2 chain order");

    // R3 hold while idle
    randomFill();
    loadChain();
    repeat (12) @(negedge clk);
    unloadChain("R3 idle hold");

    // R4 R5 R6 random runs
    for (int t = 0; t < 3; t++) begin
      randomFill();
      fullRun("R4 R5 R6 random run");
    end

    // R4 saturated grid must not wrap
    for (int k = 0; k < CHAIN; k++) model[k] = MAXV;
    fullRun("R4 all-max");

    // R6 single hot edge, truncation from zero interior
    for (int k = 0; k < CHAIN; k++) model[k] = 0;
    for (int c = 0; c < COLS; c++) model[NODES + c] = 3;
    model[NODES + 2 * COLS + ROWS + 1] = 200;
    fullRun("R6 hot edge");

    // R8 start clears done
    randomFill();
    fullRun("R8 prep");
    check("R8 done low after unload shift", int'(done), 0);
    randomFill();
    loadChain();
    pulseStart();
    repeat (MAX_ITER + 1) @(negedge clk);
    check("R8 done before restart", int'(done), 1);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R8 start clears done", int'(done), 0);
    repeat (MAX_ITER + 2) @(negedge clk);
    for (int i = 0; i < 2 * MAX_ITER; i++) modelStep();
    unloadChain("R8 restart result");

    // R9 abort after five steps
    randomFill();
    loadChain();
    pulseStart();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) modelStep();
    unloadChain("R9 abort");
    check("R9 no done after abort", int'(done), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule